// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage Integer Pipeline

This block sits beside the decode stage of a five-stage integer pipeline. Every cycle it compares the source register fields of the word in decode with the destination of the instruction in execute and, if configured, the one in memory. From that comparison it decides whether decode may proceed, whether it must use a newer operand value taken from a later stage, or whether the front end has to wait.

A static two-bit mode selects one of three policies: ignore hazards, stall on every hazard, or forward where possible and stall only where the producer is a load still in execute. The stall flag, the two forward flags and the resolved operand values are all combinational in the decode cycle.

The block also owns the decode-to-execute register. It fills that register with an all-zero nop on a stall, so a bubble enters execute while the program counter and fetch/decode register hold. A small opcode lookup classifies the decode word so that only formats that really read their second source register can raise a hazard on it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A later stage produces a hazard only when its register-write enable is 1, its destination is nonzero, and that destination equals a counted decode source field.
- R2: A match on the first source field (bits 25..21) always counts. A match on the second source field (bits 20..16) counts only when the decode word is register-format (opcode 0) or a store.
- R3: Register 0 never produces a hazard, a stall or a forward, even when a source field is also 0.
- R4: In forward mode (`hz_mode` = 2), a hazard against an execute-stage instruction with `ex_memread` = 1 raises `stall`. While stalled, both forward flags are 0 and the operand outputs equal the decode inputs.
- R5: In forward mode, a hazard against a non-load execute-stage instruction raises no stall. `ex_alu_val` replaces the first operand when the first field matches and the second operand when the counted second field matches; both may be replaced in the same cycle. The matching forward flag is 1.
- R6: In stall-only mode (`hz_mode` = 1), any hazard raises `stall`, no forward flag is ever set, and the operands pass through unchanged.
- R7: With `hz_mode` = 0 or 3, no comparison takes effect: `stall` and both forward flags stay 0 and the operands pass through.
- R8: On a clock edge with `stall` = 1, the decode-to-execute register loads all zeros (a nop with zero operands). Otherwise it loads the decode word and the resolved operand values.
- R9: Register format is opcode 0. Jump format is opcodes 2 and 3. Immediate format is opcodes 1, 4..15, 32..38 and the stores. The stores are exactly opcodes 40, 41, 42, 43 and 46. Every other opcode is unknown and is never a store.
- R10: The opcode is taken from bits 31..26, the first source field from bits 25..21 and the second source field from bits 20..16 of `id_inst`.
- R11: With the memory stage enabled (default), a memory-stage hazard stalls in stall-only mode. In forward mode it forwards `mem_val` without a stall, and an execute-stage match on the same operand takes priority over it.
- R12: While `rst_n` is low at a clock edge, the decode-to-execute register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hz_mode | input | 2 | Policy: 0 off, 1 stall-only, 2 forward, 3 off |
| id_inst | input | 32 | Instruction word in decode |
| id_rs_val | input | 32 | Register-file value of the first source |
| id_rt_val | input | 32 | Register-file value of the second source |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_dest | input | 5 | Execute-stage destination register |
| ex_alu_val | input | 32 | Execute-stage ALU result |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_dest | input | 5 | Memory-stage destination register |
| mem_val | input | 32 | Memory-stage write-back value |
| stall | output | 1 | Hold PC and fetch/decode register, inject bubble |
| fwd_rs | output | 1 | First operand was replaced by a later-stage value |
| fwd_rt | output | 1 | Second operand was replaced by a later-stage value |
| op_rs | output | 32 | Resolved first operand |
| op_rt | output | 32 | Resolved second operand |
| dx_inst | output | 32 | Decode-to-execute register: instruction |
| dx_rs_val | output | 32 | Decode-to-execute register: first operand |
| dx_rt_val | output | 32 | Decode-to-execute register: second operand |

## Verification
The assertions guard properties that hold on every cycle whatever the inputs: the off mode is silent, register 0 is inert, a non-load producer never stalls in forward mode, stall-only mode never forwards, a stall never coexists with a forward, and a stall is always followed by a zero bubble. Only the bench's sweeps can show that the right operand receives the right value, that execute wins over memory, and that the opcode lookup admits the second field for exactly the register-format and store opcodes. Those sweeps cover every opcode in every mode across all combinations of stage enables, load flag and destination matches.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard resolver.
// Assumes a 32-bit instruction word with fixed field positions.
package hz_pkg;
    localparam int INST_W = 32;
    localparam int REG_W  = 5;
    localparam int OP_W   = 6;
    localparam int OP_LSB = 26;
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;

    typedef enum logic [1:0] {
        HZ_OFF   = 2'd0,
        HZ_STALL = 2'd1,
        HZ_FWD   = 2'd2,
        HZ_RSV   = 2'd3
    } hz_mode_e;

    typedef enum logic [1:0] {
        IC_REG  = 2'd0,
        IC_IMM  = 2'd1,
        IC_JMP  = 2'd2,
        IC_UNK  = 2'd3
    } iclass_e;

    typedef struct packed {
        logic rs_hit;
        logic rt_hit;
    } hit_t;
endpackage

// File: rtl/hz_classify.sv
// Opcode lookup: instruction format and store flag.
// Assumes the opcode is already extracted; purely combinational.
module hz_classify
    import hz_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output iclass_e         cls,
    output logic            is_store
);
    // Map each opcode to its format and mark the store group.
    always_comb begin
        is_store = 1'b0;
        case (opcode) inside
            6'd0:                       cls = IC_REG;
            6'd2, 6'd3:                 cls = IC_JMP;
            6'd1, [6'd4:6'd15],
            [6'd32:6'd38]:              cls = IC_IMM;
            [6'd40:6'd43], 6'd46: begin
                cls      = IC_IMM;
                is_store = 1'b1;
            end
            default:                    cls = IC_UNK;
        endcase
    end

    // A store must always be classed as immediate format.
    always_comb begin
        assert_store_is_imm_R9: assert (!is_store || cls == IC_IMM);
    end
endmodule

// File: rtl/hz_stage_cmp.sv
// Compares one later stage's destination with the decode source fields.
// Assumes rt_used already reflects the decode word's format.
module hz_stage_cmp
    import hz_pkg::*;
(
    input  logic             regwrite,
    input  logic [REG_W-1:0] dest,
    input  logic [REG_W-1:0] src_rs,
    input  logic [REG_W-1:0] src_rt,
    input  logic             rt_used,
    output hit_t             hit
);
    logic live;

    // A stage is live only if it writes a nonzero register.
    always_comb begin
        live       = regwrite && (dest != '0);
        hit.rs_hit = live && (dest == src_rs);
        hit.rt_hit = live && rt_used && (dest == src_rt);
    end
endmodule

// File: rtl/hz_decide.sv
// Applies the selected policy to stage hits: stall, forward or pass.
// Assumes stage 0 is execute and stage 1 is memory (may be tied off).
module hz_decide
    import hz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  hz_mode_e          mode,
    input  hit_t              ex_hit,
    input  hit_t              mem_hit,
    input  logic              ex_memread,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic              stall,
    output logic              fwd_rs,
    output logic              fwd_rt,
    output logic [DATA_W-1:0] op_rs,
    output logic [DATA_W-1:0] op_rt
);
    // Policy selection; execute beats memory when both match.
    always_comb begin
        stall  = 1'b0;
        fwd_rs = 1'b0;
        fwd_rt = 1'b0;
        op_rs  = rs_val;
        op_rt  = rt_val;
        case (mode)
            HZ_STALL: stall = ex_hit.rs_hit || ex_hit.rt_hit
                           || mem_hit.rs_hit || mem_hit.rt_hit;
            HZ_FWD: begin
                stall = ex_memread && (ex_hit.rs_hit || ex_hit.rt_hit);
                if (!stall) begin
                    if (ex_hit.rs_hit) begin
                        fwd_rs = 1'b1;
                        op_rs  = ex_val;
                    end else if (mem_hit.rs_hit) begin
                        fwd_rs = 1'b1;
                        op_rs  = mem_val;
                    end
                    if (ex_hit.rt_hit) begin
                        fwd_rt = 1'b1;
                        op_rt  = ex_val;
                    end else if (mem_hit.rt_hit) begin
                        fwd_rt = 1'b1;
                        op_rt  = mem_val;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Decode-stage hazard resolver with the decode-to-execute register.
// Assumes hz_mode is static; stall holds PC and fetch/decode outside.
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter bit CHECK_MEM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hz_mode,
    input  logic [INST_W-1:0] id_inst,
    input  logic [DATA_W-1:0] id_rs_val,
    input  logic [DATA_W-1:0] id_rt_val,
    input  logic              ex_regwrite,
    input  logic              ex_memread,
    input  logic [REG_W-1:0]  ex_dest,
    input  logic [DATA_W-1:0] ex_alu_val,
    input  logic              mem_regwrite,
    input  logic [REG_W-1:0]  mem_dest,
    input  logic [DATA_W-1:0] mem_val,
    output logic              stall,
    output logic              fwd_rs,
    output logic              fwd_rt,
    output logic [DATA_W-1:0] op_rs,
    output logic [DATA_W-1:0] op_rt,
    output logic [INST_W-1:0] dx_inst,
    output logic [DATA_W-1:0] dx_rs_val,
    output logic [DATA_W-1:0] dx_rt_val
);
    localparam int NSTG = 2;

    logic [OP_W-1:0]  opcode;
    logic [REG_W-1:0] src_rs, src_rt;
    iclass_e          cls;
    logic             is_store, rt_used;
    hit_t             hits [NSTG];
    logic             stg_we   [NSTG];
    logic [REG_W-1:0] stg_dest [NSTG];
    hz_mode_e         mode;

    // Field extraction and second-field qualification.
    always_comb begin
        opcode  = id_inst[OP_LSB +: OP_W];
        src_rs  = id_inst[RS_LSB +: REG_W];
        src_rt  = id_inst[RT_LSB +: REG_W];
        rt_used = (cls == IC_REG) || is_store;
        mode    = hz_mode_e'(hz_mode);
    end

    hz_classify u_cls (
        .opcode   (opcode),
        .cls      (cls),
        .is_store (is_store)
    );

    // Gather per-stage write information into arrays.
    always_comb begin
        stg_we[0]   = ex_regwrite;
        stg_dest[0] = ex_dest;
        stg_we[1]   = mem_regwrite;
        stg_dest[1] = mem_dest;
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        if (s == 0 || CHECK_MEM) begin : g_cmp
            hz_stage_cmp u_cmp (
                .regwrite (stg_we[s]),
                .dest     (stg_dest[s]),
                .src_rs   (src_rs),
                .src_rt   (src_rt),
                .rt_used  (rt_used),
                .hit      (hits[s])
            );
        end else begin : g_off
            assign hits[s] = '0;
        end
    end

    hz_decide #(.DATA_W(DATA_W)) u_dec (
        .mode       (mode),
        .ex_hit     (hits[0]),
        .mem_hit    (hits[1]),
        .ex_memread (ex_memread),
        .rs_val     (id_rs_val),
        .rt_val     (id_rt_val),
        .ex_val     (ex_alu_val),
        .mem_val    (mem_val),
        .stall      (stall),
        .fwd_rs     (fwd_rs),
        .fwd_rt     (fwd_rt),
        .op_rs      (op_rs),
        .op_rt      (op_rt)
    );

    // Decode-to-execute register: bubble on stall, else capture.
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            dx_inst   <= '0;
            dx_rs_val <= '0;
            dx_rt_val <= '0;
        end else begin
            dx_inst   <= id_inst;
            dx_rs_val <= op_rs;
            dx_rt_val <= op_rt;
        end
    end

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hz_mode == 2'd0 || hz_mode == 2'd3) |-> (!stall && !fwd_rs && !fwd_rt));

    assert_reg0_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dest == '0 && mem_dest == '0) |-> (!stall && !fwd_rs && !fwd_rt));

    assert_no_we_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_regwrite && !mem_regwrite) |-> !stall);

    assert_nonload_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hz_mode == 2'd2 && !ex_memread) |-> !stall);

    assert_stallonly_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hz_mode == 2'd1) |-> (!fwd_rs && !fwd_rt));

    assert_stall_excl_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!fwd_rs && !fwd_rt && op_rs == id_rs_val && op_rt == id_rt_val));

    assert_bubble_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (dx_inst == '0 && dx_rs_val == '0 && dx_rt_val == '0));
endmodule

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  hz_mode;
    logic [31:0] id_inst, id_rs_val, id_rt_val;
    logic        ex_regwrite, ex_memread, mem_regwrite;
    logic [4:0]  ex_dest, mem_dest;
    logic [31:0] ex_alu_val, mem_val;
    logic        stall, fwd_rs, fwd_rt;
    logic [31:0] op_rs, op_rt, dx_inst, dx_rs_val, dx_rt_val;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hazard_fwd_unit u0 (
        .clk(clk), .rst_n(rst_n), .hz_mode(hz_mode),
        .id_inst(id_inst), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .ex_regwrite(ex_regwrite), .ex_memread(ex_memread), .ex_dest(ex_dest),
        .ex_alu_val(ex_alu_val), .mem_regwrite(mem_regwrite), .mem_dest(mem_dest),
        .mem_val(mem_val), .stall(stall), .fwd_rs(fwd_rs), .fwd_rt(fwd_rt),
        .op_rs(op_rs), .op_rt(op_rt), .dx_inst(dx_inst),
        .dx_rs_val(dx_rs_val), .dx_rt_val(dx_rt_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s mode=%0d inst=%h actual=%h expected=%h",
                     tag, hz_mode, id_inst, act, exp);
        end
    endtask

    function automatic logic [4:0] pick(input int k);
        case (k)
            0: return 5'd0;
            1: return 5'd5;
            2: return 5'd9;
            default: return 5'd3;
        endcase
    endfunction

    // R9: second field is read only by opcode 0 and the store opcodes.
    function automatic bit reads_rt(input int op);
        return op == 0 || (op >= 40 && op <= 43) || op == 46;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int iter = 0;
        rst_n        = 1'b0;
        hz_mode      = 2'd2;
        id_inst      = 32'hFFFF_FFFF;
        id_rs_val    = 32'hDEAD_BEEF;
        id_rt_val    = 32'hCAFE_F00D;
        ex_regwrite  = 1'b0;
        ex_memread   = 1'b0;
        mem_regwrite = 1'b0;
        ex_dest      = 5'd0;
        mem_dest     = 5'd0;
        ex_alu_val   = 32'h0;
        mem_val      = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset dx_inst", dx_inst, 32'h0);
        chk("R12 reset dx_rs_val", dx_rs_val, 32'h0);
        chk("R12 reset dx_rt_val", dx_rt_val, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++)
        for (int op = 0; op < 64; op++)
        for (int rsi = 0; rsi < 2; rsi++)
        for (int rti = 0; rti < 2; rti++)
        for (int ed = 0; ed < 4; ed++)
        for (int md = 0; md < 4; md++)
        for (int fl = 0; fl < 8; fl++) begin
            logic [4:0]  rs, rt;
            bit          ers, ert, mrs, mrt, e_stall, e_frs, e_frt;
            logic [31:0] e_ors, e_ort;
            @(negedge clk);
            iter++;
            rs = (rsi == 0) ? 5'd5 : 5'd0;
            rt = (rti == 0) ? 5'd9 : 5'd5;
            hz_mode      = m[1:0];
            // R10: opcode 31..26, first field 25..21, second field 20..16
            id_inst      = {op[5:0], rs, rt, 16'h7A3C};
            id_rs_val    = 32'h1000_0000 + iter;
            id_rt_val    = 32'h2000_0000 + iter;
            ex_alu_val   = 32'h3000_0000 + iter;
            mem_val      = 32'h4000_0000 + iter;
            ex_dest      = pick(ed);
            mem_dest     = pick(md);
            ex_regwrite  = fl[0];
            mem_regwrite = fl[1];
            ex_memread   = fl[2];

            // R1, R2, R3: counted matches per stage
            ers = ex_regwrite && ex_dest != 0 && ex_dest == rs;
            ert = ex_regwrite && ex_dest != 0 && ex_dest == rt && reads_rt(op);
            mrs = mem_regwrite && mem_dest != 0 && mem_dest == rs;
            mrt = mem_regwrite && mem_dest != 0 && mem_dest == rt && reads_rt(op);
            e_stall = 1'b0; e_frs = 1'b0; e_frt = 1'b0;
            e_ors = id_rs_val; e_ort = id_rt_val;
            if (m == 1) begin
                e_stall = ers || ert || mrs || mrt;              // R6, R11
            end else if (m == 2) begin
                e_stall = ex_memread && (ers || ert);            // R4
                if (!e_stall) begin                               // R5, R11
                    if (ers) begin e_frs = 1'b1; e_ors = ex_alu_val; end
                    else if (mrs) begin e_frs = 1'b1; e_ors = mem_val; end
                    if (ert) begin e_frt = 1'b1; e_ort = ex_alu_val; end
                    else if (mrt) begin e_frt = 1'b1; e_ort = mem_val; end
                end
            end
            #1;
            chk("stall R1 R2 R3 R4 R6 R7 R9", {31'b0, stall}, {31'b0, e_stall});
            chk("fwd_rs R5 R11", {31'b0, fwd_rs}, {31'b0, e_frs});
            chk("fwd_rt R5 R11", {31'b0, fwd_rt}, {31'b0, e_frt});
            chk("op_rs R5 R10", op_rs, e_ors);
            chk("op_rt R5 R10", op_rt, e_ort);
            @(posedge clk);
            #1;
            chk("dx_inst R8", dx_inst, e_stall ? 32'h0 : id_inst);
            chk("dx_rs_val R8", dx_rs_val, e_stall ? 32'h0 : e_ors);
            chk("dx_rt_val R8", dx_rt_val, e_stall ? 32'h0 : e_ort);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule